// File: doc/BRIEF.md
# Aligning Load-Store Address Unit

This unit prepares one memory access on a 32-bit data bus for a processor pipeline. It adds operand A to either operand B (register form) or an immediate (immediate form). It then forces the sum into alignment for the chosen access size and derives the byte-lane enables and the lane-positioned store data. All of these are presented on registered bus outputs. Load data returned on the bus is steered back to bit 0 and zero-extended.

Misaligned halfword and word addresses never raise an exception. The low address bits are cleared instead. Lanes are numbered big-endian: the byte at address offset 0 travels on bits 31:24. The size code is `00` for a byte, `01` for a halfword, and `10` or `11` for a word. Bit 3 of the byte-enable mask covers bits 31:24 and bit 0 covers bits 7:0.

Top module: `lsu_align_unit`

## Requirements
- R1: While rst_ni is low, bus_valid_o, bus_write_o, bus_addr_o, bus_be_o and bus_wdata_o are all zero.
- R2: A request sampled at a rising edge with req_valid_i high appears on the bus outputs after that edge with bus_valid_o high. The unmasked address is op_a_i+op_b_i when use_imm_i is 0 and op_a_i+imm_i when use_imm_i is 1, modulo 2^32.
- R3: For a halfword (size 01), bus_addr_o is the sum with bit 0 cleared.
- R4: For a word (size 1x), bus_addr_o is the sum with bits 1:0 cleared. A byte (size 00) uses the sum unchanged.
- R5: bus_be_o has one bit set for a byte, at bit 3-o where o is bus_addr_o[1:0]. A halfword enables 1100 at offset 0 and 0011 at offset 2. A word enables 1111.
- R6: bus_wdata_o holds store_data_i[7:0] in the addressed byte lane for a byte store, and store_data_i[15:0] in the addressed lane pair for a halfword store. All other lanes are zero. A word store passes store_data_i unchanged.
- R7: For a byte access, load_data_o is bus_rdata_i bits [31-8o:24-8o], zero-extended.
- R8: For a halfword access, load_data_o is the 16 bits of bus_rdata_i at lanes starting at offset o, zero-extended.
- R9: For a word access, load_data_o equals bus_rdata_i.
- R10: bus_write_o carries the write_i value sampled with the request.
- R11: An edge with req_valid_i low clears bus_valid_o and leaves bus_addr_o, bus_be_o and bus_wdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| use_imm_i | input | 1 | 1 selects the immediate instead of operand B |
| op_a_i | input | 32 | Base operand |
| op_b_i | input | 32 | Register offset operand |
| imm_i | input | 32 | Immediate offset |
| size_i | input | 2 | 00 byte, 01 halfword, 1x word |
| write_i | input | 1 | 1 for store, 0 for load |
| store_data_i | input | 32 | Store source value, low part used |
| bus_valid_o | output | 1 | Registered request valid |
| bus_write_o | output | 1 | Registered direction |
| bus_addr_o | output | 32 | Aligned address |
| bus_be_o | output | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata_o | output | 32 | Lane-positioned store data |
| bus_rdata_i | input | 32 | Read data from the bus |
| load_data_o | output | 32 | Extracted, zero-extended load result |

## Verification
The bench sweeps every size code against every low-address offset, in both operand forms and both directions, over several operand values. Each run forces the sum to a chosen offset. This separates masking of the low bits from the plain sum and tells the two halfword lane pairs apart from the four byte lanes. The read data uses distinct byte values in each lane, so a wrong shift or a missing zero extension changes the load result. Idle cycles with changed operands show that the bus outputs hold while valid drops.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  // size_i[1] set selects a full word
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] op_a_i,
  input  logic [ADDR_W-1:0] op_b_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic              use_imm_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] addr_o
);
  import lsu_align_pkg::*;
  logic [ADDR_W-1:0] sum;

  assign sum = op_a_i + (use_imm_i ? imm_i : op_b_i);

  always_comb begin
    addr_o = sum;
    if (size_i[1])              addr_o[OFF_W-1:0] = '0;
    else if (size_i == SZ_HALF) addr_o[0] = 1'b0;
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  import lsu_align_pkg::*;
  logic [OFF_W-1:0] lane_b, lane_h;

  // big-endian: offset 0 maps to the top lane
  assign lane_b = ~off_i;
  assign lane_h = ~off_i & ~{{(OFF_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (size_i[1]) begin
      be_o    = '1;
      wdata_o = store_data_i;
    end else if (size_i == SZ_HALF) begin
      be_o    = {{(LANES-2){1'b0}}, 2'b11} << lane_h;
      wdata_o = {{(DATA_W-16){1'b0}}, store_data_i[15:0]} << {lane_h, 3'b000};
    end else begin
      be_o    = {{(LANES-1){1'b0}}, 1'b1} << lane_b;
      wdata_o = {{(DATA_W-8){1'b0}}, store_data_i[7:0]} << {lane_b, 3'b000};
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] load_o
);
  import lsu_align_pkg::*;
  logic [OFF_W-1:0]  lane_b, lane_h;
  logic [DATA_W-1:0] sh_b, sh_h;

  assign lane_b = ~off_i;
  assign lane_h = ~off_i & ~{{(OFF_W-1){1'b0}}, 1'b1};
  assign sh_b   = rdata_i >> {lane_b, 3'b000};
  assign sh_h   = rdata_i >> {lane_h, 3'b000};

  always_comb begin
    if (size_i[1])              load_o = rdata_i;
    else if (size_i == SZ_HALF) load_o = {{(DATA_W-16){1'b0}}, sh_h[15:0]};
    else                        load_o = {{(DATA_W-8){1'b0}}, sh_b[7:0]};
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              use_imm_i,
  input  logic [ADDR_W-1:0] op_a_i,
  input  logic [ADDR_W-1:0] op_b_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic              bus_valid_o,
  output logic              bus_write_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [LANES-1:0]  bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] load_data_o
);
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] wdata_d;
  logic [1:0]        size_q;

  lsu_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ea (
    .op_a_i, .op_b_i, .imm_i, .use_imm_i, .size_i, .addr_o(addr_d)
  );

  lsu_lane_map #(.DATA_W(DATA_W)) u_map (
    .size_i, .off_i(addr_d[OFF_W-1:0]), .store_data_i,
    .be_o(be_d), .wdata_o(wdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_valid_o <= 1'b0;
      bus_write_o <= 1'b0;
      bus_addr_o  <= '0;
      bus_be_o    <= '0;
      bus_wdata_o <= '0;
      size_q      <= '0;
    end else begin
      bus_valid_o <= req_valid_i;
      if (req_valid_i) begin
        bus_write_o <= write_i;
        bus_addr_o  <= addr_d;
        bus_be_o    <= be_d;
        bus_wdata_o <= wdata_d;
        size_q      <= size_i;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i(size_q), .off_i(bus_addr_o[OFF_W-1:0]),
    .rdata_i(bus_rdata_i), .load_o(load_data_o)
  );
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              bus_valid_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [LANES-1:0]  bus_be_o,
  input logic [DATA_W-1:0] load_data_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> bus_valid_o);

  a_r3_half_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && $countones(bus_be_o) == 2) |-> !bus_addr_o[0]);

  a_r4_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && $countones(bus_be_o) == LANES) |-> (bus_addr_o[1:0] == 2'b00));

  a_r5_lane_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                     $countones(bus_be_o) == LANES));

  a_r7_byte_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && $countones(bus_be_o) == 1) |-> (load_data_o[DATA_W-1:8] == '0));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!bus_valid_o && $stable(bus_addr_o) && $stable(bus_be_o)));
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .bus_valid_o(bus_valid_o), .bus_addr_o(bus_addr_o),
  .bus_be_o(bus_be_o), .load_data_o(load_data_o)
);

// File: tb/tb_lsu_align_unit.sv
`timescale 1ns/1ps
module tb_lsu_align_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, use_imm = 1'b0, wr = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, imm = '0, sdata = '0, rdata = '0;
  logic [1:0] size = '0;
  logic bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata, load_data;
  logic [3:0] bus_be;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsu_align_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .use_imm_i(use_imm),
    .op_a_i(op_a), .op_b_i(op_b), .imm_i(imm), .size_i(size), .write_i(wr),
    .store_data_i(sdata), .bus_valid_o(bus_valid), .bus_write_o(bus_write),
    .bus_addr_o(bus_addr), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(rdata), .load_data_o(load_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'b0, bus_valid}, 0);
    chk("R1 write", {31'b0, bus_write}, 0);
    chk("R1 addr", bus_addr, 0);
    chk("R1 be", {28'b0, bus_be}, 0);
    chk("R1 wdata", bus_wdata, 0);
    rst_n = 1'b1;
    for (int v = 0; v < 3; v++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < 4; off++) begin
          for (int fm = 0; fm < 2; fm++) begin
            for (int w = 0; w < 2; w++) begin
              logic [31:0] a, bv, sum, ea, exp_wd, exp_ld;
              logic [3:0] exp_be;
              int eo;
              seed = seed * 32'd1664525 + 32'd1013904223;
              a  = seed ^ (v * 32'h0101_0101);
              bv = {seed[15:0], seed[31:16]};
              bv[1:0] = 2'(off - int'(a[1:0]));
              sum = a + bv;
              @(negedge clk);
              req_valid = 1'b1; use_imm = fm[0]; wr = w[0]; size = sz[1:0];
              op_a = a;
              op_b = fm ? ~bv : bv;
              imm  = fm ? bv : ~bv;
              sdata = ~seed;
              ea = sum;
              if (sz >= 2) ea[1:0] = 2'b00;
              else if (sz == 1) ea[0] = 1'b0;
              eo = int'(ea[1:0]);
              if (sz >= 2) begin
                exp_be = 4'b1111; exp_wd = sdata;
              end else if (sz == 1) begin
                exp_be = (eo == 0) ? 4'b1100 : 4'b0011;
                exp_wd = {16'b0, sdata[15:0]} << (8 * (2 - eo));
              end else begin
                exp_be = 4'b1000 >> eo;
                exp_wd = {24'b0, sdata[7:0]} << (8 * (3 - eo));
              end
              @(negedge clk);
              req_valid = 1'b0;
              chk("R2 valid", {31'b0, bus_valid}, 1);
              chk("R10 write", {31'b0, bus_write}, w);
              if (sz >= 2)      chk("R4 word addr", bus_addr, ea);
              else if (sz == 1) chk("R3 half addr", bus_addr, ea);
              else              chk("R2 byte addr", bus_addr, ea);
              chk("R5 be", {28'b0, bus_be}, {28'b0, exp_be});
              chk("R6 wdata", bus_wdata, exp_wd);
              rdata = 32'hA1B2_C3D4 ^ seed;
              if (sz >= 2)      exp_ld = rdata;
              else if (sz == 1) exp_ld = (rdata >> (8 * (2 - eo))) & 32'h0000_FFFF;
              else              exp_ld = (rdata >> (8 * (3 - eo))) & 32'h0000_00FF;
              #1;
              if (sz >= 2)      chk("R9 load word", load_data, exp_ld);
              else if (sz == 1) chk("R8 load half", load_data, exp_ld);
              else              chk("R7 load byte", load_data, exp_ld);
            end
          end
        end
      end
    end
    // R11 idle: change operands, outputs hold, valid low
    begin
      logic [31:0] ha, hw;
      logic [3:0] hb;
      ha = bus_addr; hw = bus_wdata; hb = bus_be;
      op_a = 32'hDEAD_BEEF; op_b = 32'h3; size = 2'b00; sdata = 32'h55;
      @(negedge clk);
      @(negedge clk);
      chk("R11 valid low", {31'b0, bus_valid}, 0);
      chk("R11 addr hold", bus_addr, ha);
      chk("R11 be hold", {28'b0, hb}, {28'b0, bus_be});
      chk("R11 wdata hold", bus_wdata, hw);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule